// File: doc/BRIEF.md
# Audio Clock Ratio and Speed Detector

This block runs on the master clock of an audio DAC. It measures how many master clock cycles fit into one period of the frame (word-select) clock and names the nearest supported ratio. From that ratio, or from two manual speed bits, it settles the sampling speed mode. It also gives the divide factor that brings the master clock down to a fixed 64·fs internal rate, which is the bit clock rate. It holds the converter in power-down until the frame clock toggles and a ratio has been confirmed.

Control comes from one of two places. In serial control, an internal configuration register holds an auto-setting bit and two manual speed bits; software writes it with a single-cycle write strobe. In pin control, a package pin picks manual normal speed or auto setting, and the manual speed bits are tied to zero. Ratio tracking is a four-state machine. `ST_IDLE` waits for the first frame edge. `ST_FIRST` times the first full period. `ST_TRACK` waits for two measurements in a row that agree. `ST_LOCK` is the running state. Each state moves on at a frame rising edge, and each state other than `ST_IDLE` returns to `ST_IDLE` when the frame clock times out.

Top module: `audclk_ratio_det`

## Requirements
- R1: After reset, `ratio_o`=7, `div_o`=0, `pwrdn_o`=1, `clocks_ok_o`=0, `ratio_err_o`=0 and `speed_o`=0. The configuration register resets to auto=1 with speed bits 00, so the block starts in auto mode.
- R2: A period is the number of master clock cycles between two successive frame rising edges. It is classified to code 0..5 for 128, 192, 256, 384, 512 or 768 cycles when it lies within ±2 cycles of that value. Any other period gives code 7, meaning no match.
- R3: `ratio_o` takes a new code only when two back-to-back period measurements give that same code. A single odd period leaves it unchanged.
- R4: `clocks_ok_o` rises at the first frame rising edge. If 2048 master clock cycles pass with no rising edge, `clocks_ok_o` returns to 0, `pwrdn_o` to 1 and `ratio_o` to 7.
- R5: `pwrdn_o` stays 1 until the third frame rising edge after the clocks start, which is where the two agreeing measurements complete. It falls only after `clocks_ok_o` is already 1.
- R6: In manual mode, the effective speed bits select `speed_o`: 00 gives 0 (normal), 01 gives 1 (double), 10 gives 2 (quad), and 11 is treated as normal. In auto mode, the speed bits have no effect.
- R7: In auto mode, `speed_o` follows the locked code: 512 or 768 gives 0, 256 or 384 gives 1, and 128 or 192 gives 2. Before lock, `speed_o` is 0.
- R8: When locked, `ratio_err_o`=1 in any of these cases: the code is 7; manual normal mode with a code below 2; manual double mode with a code above 3; manual quad mode with a code above 1. Auto mode accepts codes 0..5. While `pwrdn_o`=1, `ratio_err_o`=0.
- R9: With `pin_ctl_i`=1, the speed bits act as 00 whatever the register holds. `auto_pin_i`=0 selects manual normal speed and `auto_pin_i`=1 selects auto. Codes 0 and 1 (128 and 192) always raise `ratio_err_o` in pin control.
- R10: When locked on a code from 0 to 5, `div_o` equals the ratio divided by 64 (2, 3, 4, 6, 8 or 12). Otherwise `div_o` is 0.
- R11: A clock edge with `cfg_we_i`=1 loads `cfg_auto_i` and `cfg_speed_i` into the configuration register, and the new setting takes effect from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_n_i | input | 1 | Active-low power-down reset |
| frame_i | input | 1 | Frame clock, asynchronous to `clk_i` |
| pin_ctl_i | input | 1 | 1 = pin control, 0 = serial register control |
| auto_pin_i | input | 1 | Auto-setting pin, used in pin control |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_auto_i | input | 1 | Auto-setting bit to write |
| cfg_speed_i | input | 2 | Manual speed bits to write |
| speed_o | output | 2 | Speed mode: 0 normal, 1 double, 2 quad |
| ratio_o | output | 3 | Locked ratio code, 7 = none |
| ratio_err_o | output | 1 | Locked ratio unsupported in current mode |
| div_o | output | 4 | Master clock divide factor to 64·fs, 0 when unlocked |
| clocks_ok_o | output | 1 | Frame clock present |
| pwrdn_o | output | 1 | Converter held in power-down |

## Verification
A wrong internal state shows up at the ports within one frame period. If the tracking state machine enters `ST_LOCK` too early or too late, `pwrdn_o` falls at the wrong frame edge. A corrupted agreement register either lets one odd period replace `ratio_o` or keeps a real ratio change from ever appearing. A wrong period count or a wrong window bound moves a period of ratio ±2 or ratio ±3 into the wrong code, and `div_o` then changes with it. Mistakes in the mode selection show up as wrong `speed_o` and `ratio_err_o` values under the configuration sweep, which the bench applies to every locked period.

// File: rtl/audclk_pkg.sv
`timescale 1ns/1ps
package audclk_pkg;
    localparam int NUM_RATIOS = 6;
    localparam int CODE_W     = 3;

    typedef logic [CODE_W-1:0] ratio_code_t;
    localparam ratio_code_t CODE_NONE = 3'd7;

    typedef enum logic [1:0] {
        SPD_NORMAL = 2'd0,
        SPD_DOUBLE = 2'd1,
        SPD_QUAD   = 2'd2
    } speed_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_TRACK,
        ST_LOCK
    } lock_state_t;

    // even codes are 128 * 2^k, odd codes are 192 * 2^k
    function automatic int unsigned ratio_value(input int unsigned code);
        int unsigned base;
        base = ((code % 2) == 0) ? 32'd128 : 32'd192;
        return base << (code / 2);
    endfunction

    // R7: the ratio alone implies the speed class in auto mode
    function automatic speed_t speed_from_code(input ratio_code_t code);
        if (code >= 3'd4)      return SPD_NORMAL;
        else if (code >= 3'd2) return SPD_DOUBLE;
        else                   return SPD_QUAD;
    endfunction
endpackage

// File: rtl/audclk_edge_det.sv
`timescale 1ns/1ps
module audclk_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) sh_q <= '0;
        else          sh_q <= {sh_q[STAGES-1:0], async_i};
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/audclk_period_meter.sv
`timescale 1ns/1ps
module audclk_period_meter
    import audclk_pkg::*;
#(
    parameter int TOL     = 2,
    parameter int TIMEOUT = 2048
) (
    input  logic        clk_i,
    input  logic        rst_n_i,
    input  logic        rise_i,
    output ratio_code_t class_o,
    output logic        timeout_o
);
    localparam int CNT_W = $clog2(TIMEOUT) + 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

    logic [CNT_W-1:0]      cnt_q;
    logic [CNT_W-1:0]      meas;
    logic [NUM_RATIOS-1:0] hit;

    // R4: saturating count of cycles since the last frame rising edge
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i)              cnt_q <= '0;
        else if (rise_i)           cnt_q <= '0;
        else if (cnt_q != CNT_LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign meas      = cnt_q + 1'b1;
    assign timeout_o = !rise_i && (cnt_q == CNT_LAST);

    // R2: one tolerance window per supported ratio
    for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_win
        localparam int RV = int'(ratio_value(g));
        assign hit[g] = (meas >= CNT_W'(RV - TOL)) && (meas <= CNT_W'(RV + TOL));
    end

    always_comb begin
        class_o = CODE_NONE;
        for (int i = 0; i < NUM_RATIOS; i++) begin
            if (hit[i]) class_o = ratio_code_t'(i);
        end
    end
endmodule

// File: rtl/audclk_lock_fsm.sv
`timescale 1ns/1ps
module audclk_lock_fsm
    import audclk_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_n_i,
    input  logic        rise_i,
    input  logic        timeout_i,
    input  ratio_code_t class_i,
    output ratio_code_t ratio_o,
    output logic        clocks_ok_o,
    output logic        locked_o
);
    lock_state_t state_q, state_d;
    ratio_code_t prev_q, ratio_q;
    logic        agree;

    assign agree = (class_i == prev_q);

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) state_q <= ST_IDLE;
        else          state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (rise_i) state_d = ST_FIRST;
            ST_FIRST: begin
                if (timeout_i)   state_d = ST_IDLE;
                else if (rise_i) state_d = ST_TRACK;
            end
            ST_TRACK: begin
                if (timeout_i)            state_d = ST_IDLE;
                else if (rise_i && agree) state_d = ST_LOCK;   // R5
            end
            ST_LOCK:  if (timeout_i) state_d = ST_IDLE;        // R4
        endcase
    end

    // R3: the candidate code must repeat before it is reported
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            prev_q  <= CODE_NONE;
            ratio_q <= CODE_NONE;
        end else if (state_q == ST_IDLE || timeout_i) begin
            prev_q  <= CODE_NONE;
            ratio_q <= CODE_NONE;
        end else if (rise_i && state_q != ST_FIRST) begin
            prev_q <= class_i;
            if (agree) ratio_q <= class_i;
        end else if (rise_i) begin
            prev_q <= class_i;
        end
    end

    always_comb begin
        clocks_ok_o = (state_q != ST_IDLE);
        locked_o    = (state_q == ST_LOCK);
        ratio_o     = ratio_q;
    end
endmodule

// File: rtl/audclk_mode_sel.sv
`timescale 1ns/1ps
module audclk_mode_sel
    import audclk_pkg::*;
#(
    parameter int DIV_W    = 4,
    parameter int DIV_UNIT = 64
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             cfg_we_i,
    input  logic             cfg_auto_i,
    input  logic [1:0]       cfg_speed_i,
    input  logic             pin_ctl_i,
    input  logic             auto_pin_i,
    input  logic             locked_i,
    input  ratio_code_t      code_i,
    output speed_t           speed_o,
    output logic             err_o,
    output logic [DIV_W-1:0] div_o
);
    logic       auto_q;
    logic [1:0] spd_q;
    logic       auto_eff;
    logic [1:0] man_bits;
    speed_t     man_speed;
    logic       allowed;

    // R1, R11: configuration register, auto on after reset
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            auto_q <= 1'b1;
            spd_q  <= 2'b00;
        end else if (cfg_we_i) begin
            auto_q <= cfg_auto_i;
            spd_q  <= cfg_speed_i;
        end
    end

    // R9: pin control ties the speed bits low
    assign auto_eff = pin_ctl_i ? auto_pin_i : auto_q;
    assign man_bits = pin_ctl_i ? 2'b00 : spd_q;

    always_comb begin
        unique case (man_bits)
            2'b01:   man_speed = SPD_DOUBLE;
            2'b10:   man_speed = SPD_QUAD;
            default: man_speed = SPD_NORMAL;   // R6
        endcase
    end

    always_comb begin
        if (auto_eff) speed_o = locked_i ? speed_from_code(code_i) : SPD_NORMAL;
        else          speed_o = man_speed;
    end

    // R8: legal ratio sets per mode
    always_comb begin
        allowed = 1'b0;
        if (code_i == CODE_NONE)               allowed = 1'b0;
        else if (pin_ctl_i && code_i < 3'd2)   allowed = 1'b0;
        else if (auto_eff)                     allowed = 1'b1;
        else begin
            unique case (man_speed)
                SPD_NORMAL: allowed = (code_i >= 3'd2);
                SPD_DOUBLE: allowed = (code_i <= 3'd3);
                SPD_QUAD:   allowed = (code_i <= 3'd1);
                default:    allowed = 1'b0;
            endcase
        end
    end

    assign err_o = locked_i && !allowed;

    // R10: divide factor to a fixed internal rate
    always_comb begin
        if (locked_i && code_i != CODE_NONE)
            div_o = DIV_W'(ratio_value(int'(code_i)) / DIV_UNIT);
        else
            div_o = '0;
    end
endmodule

// File: rtl/audclk_ratio_det.sv
`timescale 1ns/1ps
module audclk_ratio_det
    import audclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TOL         = 2,
    parameter int TIMEOUT     = 2048,
    parameter int DIV_W       = 4
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             frame_i,
    input  logic             pin_ctl_i,
    input  logic             auto_pin_i,
    input  logic             cfg_we_i,
    input  logic             cfg_auto_i,
    input  logic [1:0]       cfg_speed_i,
    output logic [1:0]       speed_o,
    output logic [2:0]       ratio_o,
    output logic             ratio_err_o,
    output logic [DIV_W-1:0] div_o,
    output logic             clocks_ok_o,
    output logic             pwrdn_o
);
    logic        rise;
    logic        timeout;
    logic        locked;
    ratio_code_t cls;
    ratio_code_t code;
    speed_t      speed;

    audclk_edge_det #(.STAGES(SYNC_STAGES)) i_edge (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .async_i (frame_i),
        .rise_o  (rise)
    );

    audclk_period_meter #(.TOL(TOL), .TIMEOUT(TIMEOUT)) i_meter (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .rise_i    (rise),
        .class_o   (cls),
        .timeout_o (timeout)
    );

    audclk_lock_fsm i_fsm (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .rise_i      (rise),
        .timeout_i   (timeout),
        .class_i     (cls),
        .ratio_o     (code),
        .clocks_ok_o (clocks_ok_o),
        .locked_o    (locked)
    );

    audclk_mode_sel #(.DIV_W(DIV_W)) i_mode (
        .clk_i       (clk_i),
        .rst_n_i     (rst_n_i),
        .cfg_we_i    (cfg_we_i),
        .cfg_auto_i  (cfg_auto_i),
        .cfg_speed_i (cfg_speed_i),
        .pin_ctl_i   (pin_ctl_i),
        .auto_pin_i  (auto_pin_i),
        .locked_i    (locked),
        .code_i      (code),
        .speed_o     (speed),
        .err_o       (ratio_err_o),
        .div_o       (div_o)
    );

    assign speed_o = speed;
    assign ratio_o = code;
    assign pwrdn_o = !locked;
endmodule

// File: rtl/audclk_ratio_det_chk.sv
`timescale 1ns/1ps
module audclk_ratio_det_chk #(
    parameter int DIV_W = 4
) (
    input logic             clk_i,
    input logic             rst_n_i,
    input logic             pin_ctl_i,
    input logic             auto_pin_i,
    input logic [1:0]       speed_o,
    input logic [2:0]       ratio_o,
    input logic             ratio_err_o,
    input logic [DIV_W-1:0] div_o,
    input logic             clocks_ok_o,
    input logic             pwrdn_o
);
    AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_n_i) ratio_o != 3'd6); // R2
    AST_NONE_WITHOUT_CLOCKS: assert property (@(posedge clk_i) disable iff (!rst_n_i) !clocks_ok_o |-> ratio_o == 3'd7); // R4
    AST_PD_WITHOUT_CLOCKS: assert property (@(posedge clk_i) disable iff (!rst_n_i) !clocks_ok_o |-> pwrdn_o); // R5
    AST_PD_RELEASE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_n_i) $fell(pwrdn_o) |-> $past(clocks_ok_o)); // R5
    AST_PIN_MANUAL_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_n_i) (pin_ctl_i && !auto_pin_i) |-> speed_o == 2'd0); // R9
    AST_PIN_LOW_RATIO: assert property (@(posedge clk_i) disable iff (!rst_n_i) (pin_ctl_i && !pwrdn_o && ratio_o <= 3'd1) |-> ratio_err_o); // R9
    AST_NO_ERR_IN_PD: assert property (@(posedge clk_i) disable iff (!rst_n_i) pwrdn_o |-> !ratio_err_o); // R8
    AST_DIV_ZERO_IN_PD: assert property (@(posedge clk_i) disable iff (!rst_n_i) pwrdn_o |-> div_o == '0); // R10
endmodule

bind audclk_ratio_det audclk_ratio_det_chk #(.DIV_W(DIV_W)) i_chk (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .pin_ctl_i   (pin_ctl_i),
    .auto_pin_i  (auto_pin_i),
    .speed_o     (speed_o),
    .ratio_o     (ratio_o),
    .ratio_err_o (ratio_err_o),
    .div_o       (div_o),
    .clocks_ok_o (clocks_ok_o),
    .pwrdn_o     (pwrdn_o)
);

// File: tb/test_audclk_ratio_det.sv
`timescale 1ns/1ps
module test_audclk_ratio_det;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame = 1'b0;
    logic       pin_ctl = 1'b0;
    logic       auto_pin = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_auto = 1'b0;
    logic [1:0] cfg_speed = 2'b00;
    logic [1:0] speed;
    logic [2:0] ratio;
    logic       ratio_err;
    logic [3:0] div;
    logic       clocks_ok;
    logic       pwrdn;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit sh_auto = 1'b1;
    int sh_spd = 0;

    always #2.5 clk = ~clk;

    audclk_ratio_det i_audclk_ratio_det (
        .clk_i(clk), .rst_n_i(rst_n), .frame_i(frame), .pin_ctl_i(pin_ctl),
        .auto_pin_i(auto_pin), .cfg_we_i(cfg_we), .cfg_auto_i(cfg_auto),
        .cfg_speed_i(cfg_speed), .speed_o(speed), .ratio_o(ratio),
        .ratio_err_o(ratio_err), .div_o(div), .clocks_ok_o(clocks_ok), .pwrdn_o(pwrdn)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic one_frame(input int p);
        frame = 1'b1;
        repeat (p / 2) @(negedge clk);
        frame = 1'b0;
        repeat (p - p / 2) @(negedge clk);
    endtask

    task automatic write_cfg(input bit a, input int s);
        cfg_we = 1'b1; cfg_auto = a; cfg_speed = 2'(s);
        @(negedge clk);
        cfg_we = 1'b0;
        sh_auto = a; sh_spd = s;
    endtask

    function automatic int rval(input int code);
        int t[6] = '{128, 192, 256, 384, 512, 768};
        return t[code];
    endfunction

    function automatic int exp_code(input int p);
        for (int i = 0; i < 6; i++)
            if (p >= rval(i) - 2 && p <= rval(i) + 2) return i;
        return 7;
    endfunction

    function automatic bit eff_auto();
        return pin_ctl ? auto_pin : sh_auto;
    endfunction

    function automatic int eff_man();
        int b;
        b = pin_ctl ? 0 : sh_spd;
        return (b == 3) ? 0 : b;
    endfunction

    function automatic int exp_speed(input int c);
        if (!eff_auto()) return eff_man();
        if (c == 7) return 0;
        if (rval(c) >= 512) return 0;
        if (rval(c) >= 256) return 1;
        return 2;
    endfunction

    function automatic int exp_err(input int c);
        if (c == 7) return 1;
        if (pin_ctl && rval(c) < 256) return 1;
        if (eff_auto()) return 0;
        case (eff_man())
            0: return (rval(c) < 256) ? 1 : 0;
            1: return (rval(c) > 384) ? 1 : 0;
            default: return (rval(c) > 192) ? 1 : 0;
        endcase
    endfunction

    function automatic int exp_div(input int c);
        return (c == 7) ? 0 : rval(c) / 64;
    endfunction

    task automatic check_locked(input string tag, input int c);
        check(tag, "speed", int'(speed), exp_speed(c));
        check(tag, "ratio_err", int'(ratio_err), exp_err(c));
        check("R2", "ratio", int'(ratio), c);
        check("R10", "div", int'(div), exp_div(c));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (all requirements): actual hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int periods[12] = '{128, 192, 256, 384, 512, 768, 254, 258, 259, 386, 389, 765};
        wait_cyc(10);
        rst_n = 1'b1;
        wait_cyc(3000);
        // R1 reset state, no frame clock yet
        check("R1", "ratio", int'(ratio), 7);
        check("R1", "div", int'(div), 0);
        check("R1", "pwrdn", int'(pwrdn), 1);
        check("R1", "clocks_ok", int'(clocks_ok), 0);
        check("R1", "ratio_err", int'(ratio_err), 0);
        check("R1", "speed", int'(speed), 0);

        // R4, R5: lock sequence
        one_frame(256);
        check("R4", "clocks_ok after first edge", int'(clocks_ok), 1);
        check("R5", "pwrdn after first edge", int'(pwrdn), 1);
        one_frame(256);
        check("R5", "pwrdn after one measurement", int'(pwrdn), 1);
        check("R3", "ratio after one measurement", int'(ratio), 7);
        one_frame(256);
        check("R5", "pwrdn after lock", int'(pwrdn), 0);
        check("R1", "auto by default speed", int'(speed), 1);
        check("R7", "auto speed 256", int'(speed), 1);

        // near-exhaustive sweep of periods x configurations
        foreach (periods[k]) begin
            int p = periods[k];
            int c = exp_code(p);
            pin_ctl = 1'b0;
            write_cfg(1'b1, 0);
            for (int f = 0; f < 4; f++) one_frame(p);
            check("R5", "pwrdn locked", int'(pwrdn), 0);
            check("R4", "clocks_ok", int'(clocks_ok), 1);
            check_locked("R7", c);
            write_cfg(1'b1, 1);
            wait_cyc(1);
            check_locked("R6", c);
            for (int s = 0; s < 4; s++) begin
                write_cfg(1'b0, s);
                wait_cyc(1);
                check_locked("R8", c);
            end
            write_cfg(1'b0, 2);
            pin_ctl = 1'b1;
            for (int ap = 0; ap < 2; ap++) begin
                auto_pin = ap[0];
                wait_cyc(1);
                check_locked("R9", c);
            end
            pin_ctl = 1'b0;
            auto_pin = 1'b0;
            write_cfg(1'b1, 0);
            wait_cyc(1);
            check("R11", "speed after write back to auto", int'(speed), exp_speed(c));
        end

        // R3: one odd period does not move the ratio, a change needs two
        for (int f = 0; f < 4; f++) one_frame(512);
        check("R3", "ratio base", int'(ratio), 4);
        one_frame(300);
        one_frame(512);
        check("R3", "after odd period", int'(ratio), 4);
        one_frame(512);
        check("R3", "after recovery", int'(ratio), 4);
        one_frame(768);
        one_frame(768);
        check("R3", "after one new measurement", int'(ratio), 4);
        one_frame(768);
        check("R3", "after two new measurements", int'(ratio), 5);

        // R4: timeout boundary, 768 cycles already elapsed since last rise
        wait_cyc(1000);
        check("R4", "clocks_ok before timeout", int'(clocks_ok), 1);
        check("R4", "ratio before timeout", int'(ratio), 5);
        wait_cyc(400);
        check("R4", "clocks_ok after timeout", int'(clocks_ok), 0);
        check("R4", "pwrdn after timeout", int'(pwrdn), 1);
        check("R4", "ratio after timeout", int'(ratio), 7);
        check("R10", "div after timeout", int'(div), 0);

        // R1: reset restores auto even after a manual write
        write_cfg(1'b0, 2);
        rst_n = 1'b0;
        wait_cyc(5);
        rst_n = 1'b1;
        sh_auto = 1'b1; sh_spd = 0;
        for (int f = 0; f < 4; f++) one_frame(256);
        check("R1", "speed auto after reset", int'(speed), 1);
        check("R1", "ratio after relock", int'(ratio), 2);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule